// File: doc/BRIEF.md
# Byte-Lane Masked Single-Port RAM

This block is a synchronous single-port RAM. One address serves both reads and writes. The word is split into byte lanes of 8 bits, or of 9 bits where the ninth bit holds parity or a spare flag, and each lane has its own enable bit. Address, write data, write enable and lane enables are captured on a rising clock edge. A captured write updates only the enabled lanes, and the written data is forwarded to the read output for the rest of that cycle. When no write is captured, the output shows the stored word at the captured address.

A parameter adds an output register with its own clock enable and synchronous clear, at the cost of one cycle of latency. The storage can be preloaded with a fill pattern. The read output still comes up as zero after reset. A word made of a single lane has no byte masking: its lane-enable input is ignored.

Top module: `ram_be_sp`

## Requirements
- R1: Lane-enable bit i controls data bits [i*LANE_W +: LANE_W], with LANE_W set to 8 or 9. For example, with four 9-bit lanes, bit 2 covers bits [26:18].
- R2: A lane is written on the edge after capture only when the captured write enable and that lane's captured enable bit are both 1. Every other lane keeps the value last written to it.
- R3: Any lane-enable pattern is legal. With all bits at 0, a write changes no stored lane. With all bits at 1, the whole word is written.
- R4: With the output register bypassed, the cycle that follows the edge capturing a write shows the new data on every enabled lane. The masked lanes are undefined in that cycle.
- R5: With the output register bypassed and write enable at 0, the stored word at the captured address is on rdata_o in the cycle after the capturing edge. This holds over the full address range.
- R6: From reset until the first clock edge after reset is released, rdata_o reads zero, whatever the preloaded array contents are.
- R7: When NUM_LANES is 1, be_i is ignored and a write is controlled by we_i alone.
- R8: With OUT_REG = 1, rdata_o shows each read or forwarded value one cycle later than the bypassed output would.
- R9: With OUT_REG = 1, rdata_o holds its value across an edge where out_ce_i is 0.
- R10: With OUT_REG = 1, out_clr_i at 1 clears the output register to zero on the next edge, taking priority over out_ce_i. rst_ni at 0 clears it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write enable |
| be_i | input | NUM_LANES | Per-lane write enables |
| addr_i | input | $clog2(DEPTH) | Shared read/write address |
| wdata_i | input | NUM_LANES*LANE_W | Write data |
| out_ce_i | input | 1 | Output register clock enable |
| out_clr_i | input | 1 | Output register synchronous clear |
| rdata_o | output | NUM_LANES*LANE_W | Read data |

## Verification
The bench builds three instances. The first has four 9-bit lanes, a depth of 256, a bypassed output and a nonzero fill. It reaches the 36-bit lane map, every masking pattern class, forwarding on writes, and reads at address 0 and at the top address. It also reaches the zero output after reset over a nonzero array. The second has two 8-bit lanes and the output register. It exposes the extra cycle of latency, holding while the clock enable is low, and clear priority. The third has a single 8-bit lane, where the lane-enable input must have no effect.

// File: rtl/ram_be_pkg.sv
`timescale 1ns/1ps
package ram_be_pkg;
  localparam int unsigned LANE_W_PLAIN  = 8;
  localparam int unsigned LANE_W_PARITY = 9;

  // byte masking exists only for multi-lane words
  function automatic bit masking_on(input int unsigned lanes);
    return lanes > 1;
  endfunction

  function automatic bit lane_w_ok(input int unsigned w);
    return (w == LANE_W_PLAIN) || (w == LANE_W_PARITY);
  endfunction
endpackage

// File: rtl/ram_be_in_stage.sv
`timescale 1ns/1ps
module ram_be_in_stage
  import ram_be_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned LANE_W    = 9,
  parameter int unsigned AW        = 8,
  localparam int unsigned DW       = NUM_LANES * LANE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [NUM_LANES-1:0] be_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic                 we_o,
  output logic [NUM_LANES-1:0] be_o,
  output logic [AW-1:0]        addr_o,
  output logic [DW-1:0]        wdata_o,
  output logic                 vld_o
);
  localparam bit MaskOn = masking_on(NUM_LANES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      be_o    <= '1;  // enables clear to all lanes on
      addr_o  <= '0;
      wdata_o <= '0;
      vld_o   <= 1'b0;
    end else begin
      we_o    <= we_i;
      be_o    <= MaskOn ? be_i : '1;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      vld_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/ram_be_lane_bank.sv
`timescale 1ns/1ps
module ram_be_lane_bank #(
  parameter int unsigned DEPTH     = 256,
  parameter int unsigned AW        = 8,
  parameter int unsigned LANE_W    = 9,
  parameter int unsigned INIT_FILL = 0
) (
  input  logic              clk_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);
  logic [LANE_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < int'(DEPTH); i++) mem[i] = LANE_W'(INIT_FILL);
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[addr_i] <= wdata_i;
  end

  // new data flows through while the write is pending
  assign rdata_o = wr_i ? wdata_i : mem[addr_i];
endmodule

// File: rtl/ram_be_out_stage.sv
`timescale 1ns/1ps
module ram_be_out_stage #(
  parameter int unsigned DW      = 36,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          clr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  if (OUT_REG) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q <= '0;
      else if (clr_i) q <= '0;
      else if (ce_i)  q <= data_i;
    end
    assign data_o = q;
  end else begin : g_bypass
    assign data_o = data_i;
  end
endmodule

// File: rtl/ram_be_sp.sv
`timescale 1ns/1ps
module ram_be_sp
  import ram_be_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned LANE_W    = LANE_W_PARITY,
  parameter int unsigned DEPTH     = 256,
  parameter bit          OUT_REG   = 1'b1,
  parameter int unsigned INIT_FILL = 0,
  localparam int unsigned AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned DW       = NUM_LANES * LANE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [NUM_LANES-1:0] be_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 out_ce_i,
  input  logic                 out_clr_i,
  output logic [DW-1:0]        rdata_o
);
  logic                 we_q;
  logic [NUM_LANES-1:0] be_q;
  logic [AW-1:0]        addr_q;
  logic [DW-1:0]        wdata_q;
  logic                 rd_vld;
  logic [DW-1:0]        rd_raw;
  logic [DW-1:0]        rd_gated;

  ram_be_in_stage #(
    .NUM_LANES(NUM_LANES),
    .LANE_W   (LANE_W),
    .AW       (AW)
  ) u_in (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .be_i   (be_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .we_o   (we_q),
    .be_o   (be_q),
    .addr_o (addr_q),
    .wdata_o(wdata_q),
    .vld_o  (rd_vld)
  );

  for (genvar l = 0; l < int'(NUM_LANES); l++) begin : g_lane
    ram_be_lane_bank #(
      .DEPTH    (DEPTH),
      .AW       (AW),
      .LANE_W   (LANE_W),
      .INIT_FILL(INIT_FILL)
    ) u_bank (
      .clk_i  (clk_i),
      .wr_i   (we_q & be_q[l]),
      .addr_i (addr_q),
      .wdata_i(wdata_q[l*LANE_W +: LANE_W]),
      .rdata_o(rd_raw[l*LANE_W +: LANE_W])
    );
  end

  // hide preloaded contents until the first post-reset capture
  assign rd_gated = rd_vld ? rd_raw : '0;

  ram_be_out_stage #(
    .DW     (DW),
    .OUT_REG(OUT_REG)
  ) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_i  (out_ce_i),
    .clr_i (out_clr_i),
    .data_i(rd_gated),
    .data_o(rdata_o)
  );
endmodule

// File: rtl/ram_be_sp_chk.sv
`timescale 1ns/1ps
module ram_be_sp_chk
  import ram_be_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned LANE_W    = 9,
  parameter bit          OUT_REG   = 1'b1,
  localparam int unsigned DW       = NUM_LANES * LANE_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 we_i,
  input logic [NUM_LANES-1:0] be_i,
  input logic [DW-1:0]        wdata_i,
  input logic                 out_ce_i,
  input logic                 out_clr_i,
  input logic [DW-1:0]        pre_i,
  input logic [DW-1:0]        rdata_o
);
  logic first_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) first_q <= 1'b1;
    else         first_q <= 1'b0;
  end

  initial begin
    p_lane_width_r1: assert (lane_w_ok(LANE_W));
  end

  p_reset_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> rdata_o == '0);

  for (genvar l = 0; l < int'(NUM_LANES); l++) begin : g_pt
    p_passthru_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!OUT_REG && we_i && (be_i[l] || NUM_LANES == 1))
      |=> rdata_o[l*LANE_W +: LANE_W] == $past(wdata_i[l*LANE_W +: LANE_W]));
  end

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_REG && out_ce_i && !out_clr_i) |=> rdata_o == $past(pre_i));

  p_ce_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_REG && !out_ce_i && !out_clr_i) |=> $stable(rdata_o));

  p_clr_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_REG && out_clr_i) |=> rdata_o == '0);
endmodule

bind ram_be_sp ram_be_sp_chk #(
  .NUM_LANES(NUM_LANES),
  .LANE_W   (LANE_W),
  .OUT_REG  (OUT_REG)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .be_i     (be_i),
  .wdata_i  (wdata_i),
  .out_ce_i (out_ce_i),
  .out_clr_i(out_clr_i),
  .pre_i    (rd_gated),
  .rdata_o  (rdata_o)
);

// File: tb/ram_be_sp_tb_top.sv
`timescale 1ns/1ps
module ram_be_sp_tb_top;
  localparam logic [8:0] F9 = 9'h1A5;
  localparam int NV = 15;
  // {we, be[3:0], addr[7:0], wdata[35:0], expected[35:0]}
  localparam logic [84:0] VEC [NV] = '{
    {1'b0, 4'b0000, 8'd5,   36'h0,                                   {4{F9}}},
    {1'b1, 4'b1111, 8'd5,   {9'h111, 9'h122, 9'h133, 9'h144},        {9'h111, 9'h122, 9'h133, 9'h144}},
    {1'b0, 4'b0000, 8'd5,   36'h0,                                   {9'h111, 9'h122, 9'h133, 9'h144}},
    {1'b1, 4'b0101, 8'd5,   {9'h0AA, 9'h0BB, 9'h0CC, 9'h0DD},        {9'h111, 9'h0BB, 9'h133, 9'h0DD}},
    {1'b0, 4'b0000, 8'd5,   36'h0,                                   {9'h111, 9'h0BB, 9'h133, 9'h0DD}},
    {1'b1, 4'b0000, 8'd6,   {4{9'h1FF}},                             36'h0},
    {1'b0, 4'b1111, 8'd6,   36'h0,                                   {4{F9}}},
    {1'b1, 4'b1010, 8'd6,   {9'h100, 9'h0FF, 9'h001, 9'h1FE},        {9'h100, F9, 9'h001, F9}},
    {1'b1, 4'b1000, 8'd7,   {9'h155, 9'h0, 9'h0, 9'h0},              {9'h155, F9, F9, F9}},
    {1'b0, 4'b0000, 8'd6,   36'h0,                                   {9'h100, F9, 9'h001, F9}},
    {1'b0, 4'b0000, 8'd7,   36'h0,                                   {9'h155, F9, F9, F9}},
    {1'b0, 4'b0000, 8'd5,   36'h0,                                   {9'h111, 9'h0BB, 9'h133, 9'h0DD}},
    {1'b1, 4'b1111, 8'd255, {9'h1FF, 9'h000, 9'h1FF, 9'h000},        {9'h1FF, 9'h000, 9'h1FF, 9'h000}},
    {1'b0, 4'b0000, 8'd0,   36'h0,                                   {4{F9}}},
    {1'b0, 4'b0000, 8'd255, 36'h0,                                   {9'h1FF, 9'h000, 9'h1FF, 9'h000}}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        m_we = 1'b0;
  logic [3:0]  m_be = '0;
  logic [7:0]  m_addr = '0;
  logic [35:0] m_din = '0;
  logic [35:0] m_dout;

  logic        r_we = 1'b0, r_ce = 1'b1, r_clr = 1'b0;
  logic [1:0]  r_be = '0;
  logic [3:0]  r_addr = '0;
  logic [15:0] r_din = '0;
  logic [15:0] r_dout;

  logic        n_we = 1'b0;
  logic [0:0]  n_be = '0;
  logic [3:0]  n_addr = '0;
  logic [7:0]  n_din = '0;
  logic [7:0]  n_dout;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  ram_be_sp #(.NUM_LANES(4), .LANE_W(9), .DEPTH(256), .OUT_REG(1'b0), .INIT_FILL(9'h1A5)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(m_we), .be_i(m_be), .addr_i(m_addr),
    .wdata_i(m_din), .out_ce_i(1'b1), .out_clr_i(1'b0), .rdata_o(m_dout));

  ram_be_sp #(.NUM_LANES(2), .LANE_W(8), .DEPTH(16), .OUT_REG(1'b1), .INIT_FILL(8'h3C)) dut_reg_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(r_we), .be_i(r_be), .addr_i(r_addr),
    .wdata_i(r_din), .out_ce_i(r_ce), .out_clr_i(r_clr), .rdata_o(r_dout));

  ram_be_sp #(.NUM_LANES(1), .LANE_W(8), .DEPTH(16), .OUT_REG(1'b0), .INIT_FILL(8'h77)) dut_nar_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(n_we), .be_i(n_be), .addr_i(n_addr),
    .wdata_i(n_din), .out_ce_i(1'b1), .out_clr_i(1'b0), .rdata_o(n_dout));

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp,
                     input logic [35:0] care);
    total++;
    if (((act ^ exp) & care) !== 36'h0) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (care %h)", tag, act, exp, care);
    end
  endtask

  task automatic step_m(input logic we, input logic [3:0] be, input logic [7:0] a,
                        input logic [35:0] d);
    m_we = we; m_be = be; m_addr = a; m_din = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic step_r(input logic we, input logic [3:0] a, input logic [15:0] d,
                        input logic ce, input logic clr);
    r_we = we; r_be = 2'b11; r_addr = a; r_din = d; r_ce = ce; r_clr = clr;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic step_n(input logic we, input logic be, input logic [3:0] a,
                        input logic [7:0] d);
    n_we = we; n_be = be; n_addr = a; n_din = d;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    // R6: arrays are preloaded nonzero, output must still read zero
    chk("R6 main after reset", m_dout, 36'h0, '1);
    chk("R6 reg after reset", {20'h0, r_dout}, 36'h0, '1);
    chk("R6 narrow after reset", {28'h0, n_dout}, 36'h0, '1);
    @(negedge clk);

    // R1 lane map, R2 masked lanes keep, R3 zero/all masks, R4 write forwarding, R5 reads
    for (int i = 0; i < NV; i++) begin
      logic [84:0] e;
      logic [35:0] care;
      string tag;
      e = VEC[i];
      for (int l = 0; l < 4; l++)
        care[l*9 +: 9] = (!e[84] || e[80 + l]) ? 9'h1FF : 9'h000;
      step_m(e[84], e[83:80], e[79:72], e[71:36]);
      if (e[84]) tag = (e[83:80] == 4'b0000) ? "R3 zero-mask write" : "R4 write forwarding";
      else       tag = "R2 R5 readback";
      chk($sformatf("%s vec %0d", tag, i), m_dout, e[35:0], care);
    end

    // R7: single lane ignores be_i
    step_n(1'b1, 1'b0, 4'd4, 8'h5A);
    chk("R7 narrow write with be=0 forwards", {28'h0, n_dout}, {28'h0, 8'h5A}, '1);
    step_n(1'b0, 1'b0, 4'd4, 8'h00);
    chk("R7 narrow write with be=0 stored", {28'h0, n_dout}, {28'h0, 8'h5A}, '1);
    step_n(1'b0, 1'b0, 4'd5, 8'h00);
    chk("R5 narrow untouched word", {28'h0, n_dout}, {28'h0, 8'h77}, '1);

    // R8..R10: registered output
    step_r(1'b1, 4'd2, 16'hA1B2, 1'b1, 1'b0);
    chk("R8 reg shows previous read", {20'h0, r_dout}, {20'h0, 16'h3C3C}, '1);
    step_r(1'b0, 4'd2, 16'h0, 1'b1, 1'b0);
    chk("R8 reg shows forwarded write one cycle late", {20'h0, r_dout}, {20'h0, 16'hA1B2}, '1);
    step_r(1'b0, 4'd3, 16'h0, 1'b1, 1'b0);
    chk("R8 reg readback", {20'h0, r_dout}, {20'h0, 16'hA1B2}, '1);
    step_r(1'b0, 4'd3, 16'h0, 1'b0, 1'b0);
    chk("R9 reg holds with ce low", {20'h0, r_dout}, {20'h0, 16'hA1B2}, '1);
    step_r(1'b0, 4'd2, 16'h0, 1'b1, 1'b0);
    chk("R8 reg resumes", {20'h0, r_dout}, {20'h0, 16'h3C3C}, '1);
    step_r(1'b0, 4'd2, 16'h0, 1'b1, 1'b1);
    chk("R10 clear beats ce", {20'h0, r_dout}, 36'h0, '1);
    step_r(1'b0, 4'd2, 16'h0, 1'b1, 1'b0);
    chk("R8 reg after clear", {20'h0, r_dout}, {20'h0, 16'hA1B2}, '1);

    rst_n = 1'b0;
    #0.5;
    chk("R10 async reset clears reg", {20'h0, r_dout}, 36'h0, '1);
    chk("R6 main during reset", m_dout, 36'h0, '1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end
endmodule